// File: doc/BRIEF.md
# Dual-Copy Register with Agreement-Gated Output

This block stores a data word in two flip-flop copies that load the same input on the same clock edge. For each bit, the two stored values feed an agreement element. That element passes the common value when both copies hold the same value. When the copies differ, it holds the last value on which they agreed. A short upset in either copy therefore never reaches the output. At the next clock edge both copies reload from the input and agree again.

The protected output changes in the same cycle as the capturing edge, so the block has the same one-cycle latency as a plain register. Test inputs can invert what a single copy loads on a given edge, which emulates an upset in that copy. A per-bit disagreement flag reports which bits are currently split. The flag only reports and has no effect on the output.

Top module: `dcr_dual_reg`

## Requirements
- R1: While rst_ni is low, q_o and mismatch_o are all zeros, and after reset is released both stay zero until the first rising clock edge.
- R2: With all bits of flip_a_i and flip_b_i at 0 on a rising edge, q_o after that edge equals the d_i sampled at that edge.
- R3: A bit with flip_a_i=1 and flip_b_i=0 on an edge makes copy A load the inverse of d_i. q_o for that bit then keeps its value from before that edge.
- R4: A bit with flip_b_i=1 and flip_a_i=0 on an edge makes copy B load the inverse of d_i. q_o for that bit then keeps its value from before that edge.
- R5: A bit with both flip_a_i=1 and flip_b_i=1 on an edge makes the copies agree on the inverted data, so q_o for that bit becomes the inverse of d_i.
- R6: Injection lasts one edge only. The next edge with no flip on that bit brings q_o back to d_i.
- R7: Every bit is independent. A flip on one bit leaves the other bits following R2.
- R8: After each edge, mismatch_o bit i is 1 exactly when flip_a_i[i] and flip_b_i[i] differed at that edge. mismatch_o never changes q_o.
- R9: While a bit disagrees over several consecutive edges, q_o for that bit holds the last agreed value, whatever d_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; both copies load on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; clears both copies and the held state |
| d_i | input | WIDTH | Data word to store |
| flip_a_i | input | WIDTH | Per-bit test inversion of what copy A loads on this edge |
| flip_b_i | input | WIDTH | Per-bit test inversion of what copy B loads on this edge |
| q_o | output | WIDTH | Protected output from the per-bit agreement elements |
| mismatch_o | output | WIDTH | Per-bit flag; 1 where the two copies differ |

## Verification
Two functions can act on one bit at the same edge: a new data value is captured and an upset is injected into one copy. The bench drives a word whose bits change value while flip_a_i or flip_b_i is set on those bits. The protected output must keep the old value on the flipped bits and take the new value on the others. Sustained single-copy flips while d_i keeps changing test the hold path over many edges. Flips on both copies of the same bit test the opposite case, where the copies agree on corrupted data and that value must pass through.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef enum logic {
    COPY_A = 1'b0,
    COPY_B = 1'b1
  } copy_e;

  localparam int unsigned NUM_COPIES = 2;
endpackage

// File: rtl/dcr_copy.sv
module dcr_copy #(
  parameter int unsigned   WIDTH = 8,
  parameter dcr_pkg::copy_e ID   = dcr_pkg::COPY_A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] flip_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) store_q <= '0;
    else         store_q <= d_i ^ flip_i;
  end

  assign q_o = store_q;

  if (ID != dcr_pkg::COPY_A && ID != dcr_pkg::COPY_B) begin : g_bad_id
    initial $error("dcr_copy: unknown copy id");
  end
endmodule

// File: rtl/dcr_celem.sv
module dcr_celem #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic keep_q;

    // keeper: remembers the last value driven out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) keep_q <= 1'b0;
      else         keep_q <= y_o[i];
    end

    assign y_o[i] = (a_i[i] == b_i[i]) ? a_i[i] : keep_q;
  end
endmodule

// File: rtl/dcr_dual_reg.sv
module dcr_dual_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] flip_a_i,
  input  logic [WIDTH-1:0] flip_b_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] mismatch_o
);
  localparam int unsigned NC = dcr_pkg::NUM_COPIES;

  logic [NC-1:0][WIDTH-1:0] flip_w;
  logic [NC-1:0][WIDTH-1:0] copy_w;

  assign flip_w[dcr_pkg::COPY_A] = flip_a_i;
  assign flip_w[dcr_pkg::COPY_B] = flip_b_i;

  for (genvar c = 0; c < NC; c++) begin : g_copy
    dcr_copy #(
      .WIDTH (WIDTH),
      .ID    (dcr_pkg::copy_e'(c))
    ) u_copy (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (d_i),
      .flip_i (flip_w[c]),
      .q_o    (copy_w[c])
    );
  end

  dcr_celem #(
    .WIDTH (WIDTH)
  ) u_celem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (copy_w[dcr_pkg::COPY_A]),
    .b_i    (copy_w[dcr_pkg::COPY_B]),
    .y_o    (q_o)
  );

  assign mismatch_o = copy_w[dcr_pkg::COPY_A] ^ copy_w[dcr_pkg::COPY_B];

  a_r2_clean_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_a_i == '0 && flip_b_i == '0) |=> (q_o == $past(d_i)));

  // R3, R4, R9: single-copy flip keeps the previous output bit
  a_r3_single_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flip_a_i ^ flip_b_i) & (q_o ^ $past(q_o))) == '0));

  a_r5_double_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flip_a_i & flip_b_i) & (q_o ^ ~$past(d_i))) == '0));

  a_r8_flag_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mismatch_o == $past(flip_a_i ^ flip_b_i)));

  always_comb begin
    if (!rst_ni) a_r1_reset_zero: assert (q_o == '0 && mismatch_o == '0);
  end
endmodule

// File: tb/tb_dcr_dual_reg.sv
module tb_dcr_dual_reg;
  localparam int unsigned W = 8;
  localparam time PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] d_i = '0, flip_a_i = '0, flip_b_i = '0;
  logic [W-1:0] q_o, mismatch_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q = '0, exp_m = '0;

  dcr_dual_reg #(.WIDTH(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(d_i),
    .flip_a_i(flip_a_i), .flip_b_i(flip_b_i),
    .q_o(q_o), .mismatch_o(mismatch_o)
  );

  always #(PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // requirement model: each copy loads d^flip, output passes agreement else holds
  task automatic step(input string tag, input logic [W-1:0] d,
                      input logic [W-1:0] fa, input logic [W-1:0] fb);
    logic [W-1:0] a, b;
    d_i = d; flip_a_i = fa; flip_b_i = fb;
    a = d ^ fa; b = d ^ fb;
    exp_q = (~(a ^ b) & a) | ((a ^ b) & exp_q);
    exp_m = a ^ b;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag, "q_o", q_o, exp_q);
    chk(tag, "mismatch_o", mismatch_o, exp_m);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    d_i = 8'hFF; flip_a_i = 8'h0F; flip_b_i = 8'hF0;
    repeat (2) @(negedge clk_i);
    chk("R1", "q_o in reset", q_o, '0);
    chk("R1", "mismatch_o in reset", mismatch_o, '0);
    rst_ni = 1'b1;
    #1;
    chk("R1", "q_o after release", q_o, '0);
    exp_q = '0; exp_m = '0;
  endtask

  task automatic t_plain();
    step("R2", 8'hA5, '0, '0);
    step("R2", 8'h3C, '0, '0);
    step("R2", 8'hFF, '0, '0);
    step("R2", 8'h00, '0, '0);
    chk("R2", "q_o zero word", q_o, 8'h00);
  endtask

  task automatic t_flip_a();
    step("R2", 8'hF0, '0, '0);
    // data changes on low nibble in the same edge as copy-A flip
    step("R3", 8'h0F, 8'h0F, '0);
    chk("R7", "q_o untouched bits", q_o & 8'hF0, 8'h00);
    chk("R3", "q_o held bits", q_o & 8'h0F, 8'h00);
    step("R6", 8'h0F, '0, '0);
    chk("R6", "recovered", q_o, 8'h0F);
  endtask

  task automatic t_flip_b();
    step("R2", 8'h55, '0, '0);
    step("R4", 8'hAA, '0, 8'h81);
    chk("R4", "q_o held bits", q_o & 8'h81, 8'h01);
    chk("R7", "q_o untouched bits", q_o & 8'h7E, 8'h2A);
    step("R6", 8'hAA, '0, '0);
  endtask

  task automatic t_both();
    step("R5", 8'hAA, 8'h03, 8'h03);
    chk("R5", "q_o inverted bits", q_o, 8'hA9);
    chk("R8", "no flag on agreement", mismatch_o, 8'h00);
  endtask

  task automatic t_sustained();
    step("R2", 8'h00, '0, '0);
    step("R9", 8'hFF, 8'hFF, '0);
    step("R9", 8'h5A, 8'hFF, '0);
    step("R9", 8'hC3, '0, 8'hFF);
    step("R9", 8'hFF, 8'hFF, '0);
    chk("R9", "q_o held over edges", q_o, 8'h00);
    chk("R8", "flag stays set", mismatch_o, 8'hFF);
    step("R6", 8'h96, '0, '0);
  endtask

  initial begin
    t_reset();
    @(negedge clk_i);
    t_plain();
    t_flip_a();
    t_flip_b();
    t_both();
    t_sustained();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule